// File: doc/BRIEF.md
# Register-Window Serial Bridge Engine

This block lets a host reach the 16-bit registers of a remote companion device through a plain memory-mapped port. A store into the 4 KB remote window at host addresses 0x8000 to 0x8FFF does not wait for the remote side. The store is placed in a small write queue, and a transfer engine sends the queued writes to the remote device one at a time.

Reads are posted. The host writes the wanted register offset into a command register, and that store alone launches the remote read. The host then polls a result word until its busy flag drops. The result word carries the returned value and an echo of the requested offset, so the host can confirm that the value belongs to its own request.

The remote device is modelled inside the block as a small register file. Every remote access, read or write, occupies the single access path for a fixed number of cycles. A read never overtakes a write that is still queued.

Top module: `regwin_bridge`

## Requirements
- R1: After reset the result word (host address 0x0014) reads 0x00000000, and the queue status word (host address 0x0018) reads 0x00000400: empty flag set, full flag clear, overflow flag clear.
- R2: A store to the command register (host address 0x0010) while the bridge is not busy starts a remote read with no other action. Bit 31 of the result word reads 1 from the cycle after that store.
- R3: When a read completes, bit 31 of the result word clears. Bits 15:0 then hold the remote register value. Bits 30:16 hold bits 11:0 of the stored command value, zero-extended. Command bits 31:12 are ignored.
- R4: A store whose host address has bits 15:12 equal to 0x8 queues a remote write of data bits 15:0 to offset address bits 11:0. A store to any other address besides the command register has no effect on the remote registers.
- R5: In the queue status word, bit 11 reads 1 when the write queue holds 8 entries, and bit 10 reads 1 when the queue is empty.
- R6: A window store that arrives while the queue is full is discarded, and bit 0 of the queue status word becomes 1 and stays 1 until reset.
- R7: A read does not start its remote access until the write queue is empty. A read therefore returns the data of every write queued before it.
- R8: Every remote access lasts 16 cycles. If a read command is accepted while the engine is idle and the queue is empty, bit 31 reads 1 for exactly 17 consecutive cycles.
- R9: Only one remote access is active at a time. A command store while busy is ignored, and the first request's echo and data are reported.
- R10: The remote model holds 64 registers, selected by offset bits 5:0. Offsets that differ only in bits 11:6 reach the same register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host store strobe |
| host_addr | input | 16 | Host byte address for stores and loads |
| host_wdata | input | 32 | Host store data |
| host_rdata | output | 32 | Load data for host_addr (combinational) |

## Verification
The assertions check these rules on every cycle:
- the sticky overflow flag never clears;
- a read access starts only when the write queue has been empty;
- busy rises after an accepted command;
- the register file never sees a read and a write strobe together;
- the queue is never popped while empty;
- an active access keeps its phase until its count runs out.

Some behaviour can only be shown by the bench scenarios:
- the data and address echo of each read;
- the exact 17-cycle busy window;
- the drop of the tenth store in a back-to-back burst;
- aliasing through offset bits 11:6;
- that stray stores and commands issued while busy leave no trace.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int OFF_W  = 12;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic [OFF_W-1:0]  off;
    logic [DATA_W-1:0] data;
  } wr_entry_t;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_WR   = 2'd1,
    ENG_RD   = 2'd2
  } eng_state_t;
endpackage

// File: rtl/regwin_wfifo.sv
module regwin_wfifo
  import regwin_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  wr_entry_t push_data,
  input  logic      pop,
  output wr_entry_t head,
  output logic      full,
  output logic      empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  wr_entry_t        store_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q, wptr_n, rptr_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    if (push) wptr_n = ptr_inc(wptr_q);
    if (pop)  rptr_n = ptr_inc(rptr_q);
    if (push && !pop)      cnt_n = cnt_q + 1'b1;
    else if (pop && !push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store_q[wptr_q] <= push_data;
  end

  assign head  = store_q[rptr_q];
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/regwin_remote_rf.sv
module regwin_remote_rf
  import regwin_pkg::*;
#(
  parameter int WORDS = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic                       re,
  input  logic [$clog2(WORDS)-1:0]   idx,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata
);
  logic [DATA_W-1:0] mem_q [WORDS];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (we) mem_q[idx] <= wdata;
      if (re) rdata_q <= mem_q[idx];
    end
  end

  assign rdata = rdata_q;

  p_single_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re));
endmodule

// File: rtl/regwin_engine.sv
module regwin_engine
  import regwin_pkg::*;
#(
  parameter int XFER_CYC = 16,
  parameter int RF_WORDS = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fifo_empty,
  input  wr_entry_t                     fifo_head,
  output logic                          fifo_pop,
  input  logic                          rd_req,
  input  logic [OFF_W-1:0]              rd_off,
  output logic                          rd_done,
  output logic                          rd_active,
  output logic                          rf_we,
  output logic                          rf_re,
  output logic [$clog2(RF_WORDS)-1:0]   rf_idx,
  output logic [DATA_W-1:0]             rf_wdata
);
  localparam int IDX_W = $clog2(RF_WORDS);
  localparam int CNT_W = (XFER_CYC > 1) ? $clog2(XFER_CYC) : 1;

  eng_state_t       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  wr_entry_t        ent_q, ent_n;
  logic             ent_en;
  logic             unused_hi;

  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    ent_n    = ent_q;
    ent_en   = 1'b0;
    fifo_pop = 1'b0;
    rf_we    = 1'b0;
    rf_re    = 1'b0;
    rd_done  = 1'b0;
    unique case (st_q)
      ENG_IDLE: begin
        if (!fifo_empty) begin
          fifo_pop = 1'b1;
          ent_n    = fifo_head;
          ent_en   = 1'b1;
          st_n     = ENG_WR;
          cnt_n    = CNT_W'(XFER_CYC - 1);
        end else if (rd_req) begin
          rf_re = 1'b1;
          st_n  = ENG_RD;
          cnt_n = CNT_W'(XFER_CYC - 1);
        end
      end
      ENG_WR: begin
        if (cnt_q == '0) begin
          rf_we = 1'b1;
          st_n  = ENG_IDLE;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      ENG_RD: begin
        if (cnt_q == '0) begin
          rd_done = 1'b1;
          st_n    = ENG_IDLE;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      default: st_n = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ent_q <= '0;
    else if (ent_en) ent_q <= ent_n;
  end

  assign rd_active = (st_q == ENG_RD);
  assign rf_idx    = (st_q == ENG_WR) ? ent_q.off[IDX_W-1:0] : rd_off[IDX_W-1:0];
  assign rf_wdata  = ent_q.data;
  assign unused_hi = ^{ent_q.off[OFF_W-1:IDX_W], rd_off[OFF_W-1:IDX_W]};

  p_hold_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ENG_IDLE && cnt_q != '0) |=> (st_q == $past(st_q)));
  p_done_only_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> rd_req);
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int XFER_CYC   = 16,
  parameter int RF_WORDS   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr_en,
  input  logic [15:0] host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata
);
  localparam logic [15:0] A_CMD    = 16'h0010;
  localparam logic [15:0] A_RESULT = 16'h0014;
  localparam logic [15:0] A_QSTAT  = 16'h0018;
  localparam logic [3:0]  WIN_PAGE = 4'h8;
  localparam int          IDX_W    = $clog2(RF_WORDS);

  logic              cmd_hit, win_hit, cmd_take;
  logic              busy_q, busy_n;
  logic              ovf_q, ovf_n;
  logic [OFF_W-1:0]  echo_q, echo_n;
  logic [DATA_W-1:0] res_q, res_n;
  logic              push, pop, full, empty;
  wr_entry_t         push_ent, head;
  logic              rd_done, rd_active;
  logic              rf_we, rf_re;
  logic [IDX_W-1:0]  rf_idx;
  logic [DATA_W-1:0] rf_wdata, rf_rdata;
  logic              unused_wd;

  assign cmd_hit  = host_wr_en && (host_addr == A_CMD);
  assign win_hit  = host_wr_en && (host_addr[15:12] == WIN_PAGE);
  assign cmd_take = cmd_hit && !busy_q;
  assign push     = win_hit && !full;
  assign push_ent = '{off: host_addr[OFF_W-1:0], data: host_wdata[DATA_W-1:0]};
  assign unused_wd = ^host_wdata[31:DATA_W];

  always_comb begin
    busy_n = busy_q;
    echo_n = echo_q;
    res_n  = res_q;
    ovf_n  = ovf_q;
    if (cmd_take) begin
      busy_n = 1'b1;
      echo_n = host_wdata[OFF_W-1:0];
    end else if (rd_done) begin
      busy_n = 1'b0;
      res_n  = rf_rdata;
    end
    if (win_hit && full) ovf_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      echo_q <= '0;
      res_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      echo_q <= echo_n;
      res_q  <= res_n;
      ovf_q  <= ovf_n;
    end
  end

  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      A_RESULT: host_rdata = {busy_q, 3'b000, echo_q, res_q};
      A_QSTAT:  host_rdata = {20'd0, full, empty, 9'd0, ovf_q};
      default:  host_rdata = '0;
    endcase
  end

  regwin_wfifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_ent),
    .pop(pop), .head(head), .full(full), .empty(empty)
  );

  regwin_engine #(.XFER_CYC(XFER_CYC), .RF_WORDS(RF_WORDS)) u_eng (
    .clk(clk), .rst_n(rst_n), .fifo_empty(empty), .fifo_head(head),
    .fifo_pop(pop), .rd_req(busy_q), .rd_off(echo_q), .rd_done(rd_done),
    .rd_active(rd_active), .rf_we(rf_we), .rf_re(rf_re), .rf_idx(rf_idx),
    .rf_wdata(rf_wdata)
  );

  regwin_remote_rf #(.WORDS(RF_WORDS)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .re(rf_re), .idx(rf_idx),
    .wdata(rf_wdata), .rdata(rf_rdata)
  );

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  p_read_after_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_active) |-> $past(empty));
  p_busy_on_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && !busy_q) |=> busy_q);
  p_busy_cmd_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && busy_q && !rd_done) |=> $stable(echo_q));
endmodule

// File: tb/tb_regwin_bridge.sv
module tb_regwin_bridge;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_CMD    = 16'h0010;
  localparam logic [15:0] A_RESULT = 16'h0014;
  localparam logic [15:0] A_QSTAT  = 16'h0018;

  logic        clk;
  logic        rst_n;
  logic        host_wr_en;
  logic [15:0] host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [64];

  regwin_bridge dut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_result(input logic [11:0] off);
    return {1'b0, 3'b000, off, model[off[5:0]]};
  endfunction

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    host_wr_en = 1'b1;
    host_addr  = a;
    host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] v);
    host_addr = a;
    #1;
    v = host_rdata;
  endtask

  task automatic win_store(input logic [11:0] off, input logic [15:0] d);
    logic [31:0] s;
    bus_rd(A_QSTAT, s);
    while (s[11]) begin
      @(negedge clk);
      bus_rd(A_QSTAT, s);
    end
    bus_wr({4'h8, off}, {16'hdead, d});
    model[off[5:0]] = d;
  endtask

  task automatic wait_idle(output logic [31:0] v);
    int n = 0;
    bus_rd(A_RESULT, v);
    while (v[31] && n < 400) begin
      @(negedge clk);
      bus_rd(A_RESULT, v);
      n++;
    end
  endtask

  task automatic do_read(input logic [11:0] off, input string req);
    logic [31:0] v;
    bus_wr(A_CMD, {$urandom_range(0, 32'hfffff), off});
    wait_idle(v);
    check(req, v, exp_result(off));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int          cnt;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) model[i] = '0;
    host_wr_en = 1'b0;
    host_addr  = '0;
    host_wdata = '0;
    rst_n      = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(A_RESULT, v); check("R1 result", v, 32'h0);
    bus_rd(A_QSTAT, v);  check("R1 qstat", v, 32'h0000_0400);

    // R8 busy window, R2 busy right after command
    bus_wr(A_CMD, 32'h0000_0005);
    cnt = 0;
    bus_rd(A_RESULT, v);
    check("R2 busy set", {31'd0, v[31]}, 32'd1);
    while (v[31] && cnt < 100) begin
      cnt++;
      @(negedge clk);
      bus_rd(A_RESULT, v);
    end
    check("R8 busy cycles", cnt, 32'd17);
    check("R3 result", v, exp_result(12'h005));

    // R4 / R7: write then read back, read waits for drain
    win_store(12'h003, 16'h1234);
    win_store(12'h004, 16'habcd);
    do_read(12'h003, "R7 read after write");
    do_read(12'h004, "R4 window write");

    // R10 aliasing: offset 0x0C3 reaches register 3
    win_store(12'h0c3, 16'h5a5a);
    do_read(12'h003, "R10 alias");

    // R4 stray store outside window has no effect
    bus_wr(16'h9003, 32'h0000_ffff);
    bus_wr(16'h7003, 32'h0000_eeee);
    do_read(12'h003, "R4 stray store");

    // R9 command while busy is ignored
    win_store(12'h011, 16'h0111);
    win_store(12'h012, 16'h0222);
    wait_idle(v);
    repeat (40) @(negedge clk);
    bus_wr(A_CMD, 32'h0000_0011);
    bus_wr(A_CMD, 32'h0000_0012);
    wait_idle(v);
    check("R9 ignored cmd", v, exp_result(12'h011));

    // R5 / R6 burst of 10 stores: 9 fit, the 10th drops
    repeat (40) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      bus_wr({4'h8, 12'h020 + 12'(i)}, 32'h0000_a000 + i);
      if (i < 9) model[6'h20 + 6'(i)] = 16'ha000 + 16'(i);
    end
    bus_rd(A_QSTAT, v);
    check("R5 full flag", {31'd0, v[11]}, 32'd1);
    check("R5 not empty", {31'd0, v[10]}, 32'd0);
    check("R6 overflow", {31'd0, v[0]}, 32'd1);
    do_read(12'h028, "R6 last kept");
    do_read(12'h029, "R6 dropped store");
    bus_rd(A_QSTAT, v);
    check("R5 empty after drain", v, 32'h0000_0401);

    // Random mix
    for (int k = 0; k < 60; k++) begin
      int sel;
      logic [11:0] off;
      sel = $urandom_range(0, 3);
      off = 12'($urandom_range(0, 4095));
      if (sel < 2)       win_store(off, 16'($urandom_range(0, 65535)));
      else if (sel == 2) do_read(off, "R3 random read");
      else               bus_wr({4'h1, off}, $urandom);
    end
    for (int j = 0; j < 8; j++) do_read(12'($urandom_range(0, 4095)), "R7 random final");
    bus_rd(A_QSTAT, v);
    check("R6 sticky", {31'd0, v[0]}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule